// File: doc/BRIEF.md
# Feedback Triple-Redundant Counter

This block is a binary up-counter whose state is held in three identical copies of the register. A bitwise two-of-three majority vote across the copies forms the count that leaves the block. A single upset in one copy is outvoted, so the output stays correct.

The parameter `FEEDBACK` decides what each copy counts from:

- **Feedback voting (`FEEDBACK = 1`).** Every copy takes the voted value as the base for its next state. A corrupted copy therefore realigns at the next clock edge, and the count does not stop.
- **Output-only voting (`FEEDBACK = 0`).** Each copy runs from its own register. A corrupted copy stays wrong until a synchronous reset. The voted output is still right while only one copy is wrong.

The block has these signals:

- A synchronous reset.
- A count enable.
- A per-copy disagreement flag.
- A fault-injection port that loads a chosen value into any subset of the copies for one clock. This port makes single upsets and simultaneous double upsets easy to bring about.

Top module: `tmr_fb_counter`

## Requirements
- R1: When `rst` is high at a rising edge, all three copies become zero. In the following cycle `count` is 0 and `mismatch` is 3'b000.
- R2: With `en` high and no injection or disagreement, `count` rises by exactly 1 at each edge, modulo 2^WIDTH. The value all-ones is followed by zero.
- R3: With `en` low and no injection or disagreement, `count` keeps its value across the edge.
- R4: Each bit of `count` is the majority of the same bit in the three copies. This holds even when all three copies hold different values.
- R5: `mismatch` bit k (bit 0 is copy 0, bit 1 is copy 1, bit 2 is copy 2) is high in exactly the cycles when copy k differs from `count`.
- R6: If `inj_mask` bit k is high at an edge, copy k loads `inj_value` in place of its normal next value, whatever the value of `en`. `rst` takes priority over injection.
- R7: With `FEEDBACK = 1`, every edge without injection leaves all three copies equal. A single corrupted copy clears its `mismatch` bit one clock after the upset, and `count` continues without a gap.
- R8: With `FEEDBACK = 0`, a single corrupted copy keeps its `mismatch` bit high across later edges until reset, while `count` stays correct.
- R9: If two or three `inj_mask` bits are high at an edge, `count` shows `inj_value` in the next cycle. In this case the vote is defeated, and this happens in both modes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Count enable |
| inj_mask | input | 3 | Fault-injection select, one bit per copy |
| inj_value | input | WIDTH | Value forced into the selected copies |
| count | output | WIDTH | Majority-voted count |
| mismatch | output | 3 | Per-copy disagreement with the voted count |

## Verification
The hardest states to reach from the ports are those where the copies disagree in more than one way. These include two copies corrupted at once, and all three copies holding different values in output-only mode.

The bench uses the multi-bit injection mask to get there:

- It corrupts two copies in the same clock to defeat the vote.
- It corrupts different copies on consecutive clocks to spread the three copies apart.
- It sweeps every injected value into every copy after a reset.

Two instances, one per voting mode, run side by side on the same stimulus. This exposes the difference in how each mode recovers.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
   localparam int unsigned TMR_COPIES = 3;
   localparam int unsigned TMR_SEL_W  = TMR_COPIES;

   typedef enum logic {
      VOTE_OUTPUT_ONLY = 1'b0,
      VOTE_FEEDBACK    = 1'b1
   } vote_mode_e;
endpackage

// File: rtl/tmr_voter.sv
module tmr_voter
   import tmr_pkg::*;
#(
   parameter int unsigned WIDTH = 8
) (
   input  logic [WIDTH-1:0]     copy_a,
   input  logic [WIDTH-1:0]     copy_b,
   input  logic [WIDTH-1:0]     copy_c,
   output logic [WIDTH-1:0]     voted,
   output logic [TMR_SEL_W-1:0] differs
);
   // bitwise two-of-three majority
   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      assign voted[i] = (copy_a[i] & copy_b[i]) |
                        (copy_a[i] & copy_c[i]) |
                        (copy_b[i] & copy_c[i]);
   end

   always_comb begin
      differs[0] = (copy_a != voted);
      differs[1] = (copy_b != voted);
      differs[2] = (copy_c != voted);
   end
endmodule

// File: rtl/tmr_replica.sv
module tmr_replica #(
   parameter int unsigned WIDTH    = 8,
   parameter bit          FEEDBACK = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             en,
   input  logic             force_load,
   input  logic [WIDTH-1:0] force_value,
   input  logic [WIDTH-1:0] voted,
   output logic [WIDTH-1:0] q
);
   logic [WIDTH-1:0] base;
   logic [WIDTH-1:0] nxt;

   // the base of the next state is chosen by the voting mode
   if (FEEDBACK) begin : g_fb
      assign base = voted;
   end else begin : g_own
      assign base = q;
   end

   assign nxt = en ? base + WIDTH'(1) : base;

   always_ff @(posedge clk) begin
      if (rst)             q <= '0;
      else if (force_load) q <= force_value;
      else                 q <= nxt;
   end
endmodule

// File: rtl/tmr_fb_counter.sv
module tmr_fb_counter
   import tmr_pkg::*;
#(
   parameter int unsigned WIDTH    = 8,
   parameter bit          FEEDBACK = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 en,
   input  logic [TMR_SEL_W-1:0] inj_mask,
   input  logic [WIDTH-1:0]     inj_value,
   output logic [WIDTH-1:0]     count,
   output logic [TMR_SEL_W-1:0] mismatch
);
   localparam vote_mode_e MODE = vote_mode_e'(FEEDBACK);

   if (WIDTH < 1) begin : g_bad_width
      $error("tmr_fb_counter: WIDTH must be at least 1");
   end
   if (TMR_COPIES != 3) begin : g_bad_copies
      $error("tmr_fb_counter: majority voter needs exactly three copies");
   end

   logic [WIDTH-1:0] rep_q [TMR_COPIES];
   logic [WIDTH-1:0] voted;

   for (genvar k = 0; k < TMR_COPIES; k++) begin : g_copy
      tmr_replica #(
         .WIDTH    (WIDTH),
         .FEEDBACK (MODE == VOTE_FEEDBACK)
      ) u_rep (
         .clk         (clk),
         .rst         (rst),
         .en          (en),
         .force_load  (inj_mask[k]),
         .force_value (inj_value),
         .voted       (voted),
         .q           (rep_q[k])
      );
   end

   tmr_voter #(.WIDTH(WIDTH)) u_vote (
      .copy_a  (rep_q[0]),
      .copy_b  (rep_q[1]),
      .copy_c  (rep_q[2]),
      .voted   (voted),
      .differs (mismatch)
   );

   assign count = voted;
endmodule

// File: rtl/tmr_fb_counter_chk.sv
module tmr_fb_counter_chk #(
   parameter int unsigned WIDTH    = 8,
   parameter bit          FEEDBACK = 1'b1
) (
   input logic             clk,
   input logic             rst,
   input logic             en,
   input logic [2:0]       inj_mask,
   input logic [WIDTH-1:0] inj_value,
   input logic [WIDTH-1:0] count,
   input logic [2:0]       mismatch
);
   logic rst_q = 1'b0;
   always_ff @(posedge clk) rst_q <= rst;

   // R1: the cycle after reset shows zero and full agreement
   p_reset_clears_r1: assert property (@(posedge clk) disable iff (rst)
      rst_q |-> (count == '0 && mismatch == 3'b000));

   // R2: clean counting step with wrap
   p_count_step_r2: assert property (@(posedge clk) disable iff (rst)
      (en && inj_mask == 3'b000 && mismatch == 3'b000)
      |=> count == WIDTH'($past(count) + 1'b1));

   // R3: hold when disabled
   p_hold_r3: assert property (@(posedge clk) disable iff (rst)
      (!en && inj_mask == 3'b000 && mismatch == 3'b000) |=> $stable(count));

   // R9: two or more copies forced defeats the vote
   p_double_upset_r9: assert property (@(posedge clk) disable iff (rst)
      ($countones(inj_mask) >= 2) |=> count == $past(inj_value));

   if (FEEDBACK) begin : g_fb_props
      // R7: every edge without injection realigns all copies
      p_resync_r7: assert property (@(posedge clk) disable iff (rst)
         (inj_mask == 3'b000) |=> mismatch == 3'b000);
   end else begin : g_oo_props
      // R8: a lone divergent copy stays divergent
      p_divergent_stays_r8: assert property (@(posedge clk) disable iff (rst)
         (inj_mask == 3'b000 && $onehot0(mismatch))
         |=> ((mismatch & $past(mismatch)) == $past(mismatch)));
   end
endmodule

bind tmr_fb_counter tmr_fb_counter_chk #(
   .WIDTH    (WIDTH),
   .FEEDBACK (FEEDBACK)
) u_chk (
   .clk       (clk),
   .rst       (rst),
   .en        (en),
   .inj_mask  (inj_mask),
   .inj_value (inj_value),
   .count     (count),
   .mismatch  (mismatch)
);

// File: tb/tmr_fb_counter_bench.sv
module tmr_fb_counter_bench;
   localparam int W = 4;
   localparam int M = 1 << W;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic         rst = 1'b1;
   logic         en = 1'b0;
   logic [2:0]   inj_mask = 3'b000;
   logic [W-1:0] inj_value = '0;
   logic [W-1:0] cnt_fb, cnt_oo;
   logic [2:0]   mm_fb, mm_oo;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   logic [W-1:0] mf [3];
   logic [W-1:0] mo [3];

   tmr_fb_counter #(.WIDTH(W), .FEEDBACK(1'b1)) u_tmr_fb_counter (
      .clk(clk), .rst(rst), .en(en), .inj_mask(inj_mask),
      .inj_value(inj_value), .count(cnt_fb), .mismatch(mm_fb));

   tmr_fb_counter #(.WIDTH(W), .FEEDBACK(1'b0)) u_tmr_fb_counter_oo (
      .clk(clk), .rst(rst), .en(en), .inj_mask(inj_mask),
      .inj_value(inj_value), .count(cnt_oo), .mismatch(mm_oo));

   function automatic logic [W-1:0] maj(logic [W-1:0] a, logic [W-1:0] b,
                                        logic [W-1:0] c);
      return (a & b) | (a & c) | (b & c);
   endfunction

   task automatic check(string req, string what, logic [31:0] act,
                        logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // advance one clock, update the reference and compare both instances
   task automatic step(string req);
      logic [W-1:0] nf [3];
      logic [W-1:0] no [3];
      logic [W-1:0] vf, vo;
      logic [2:0]   ef, eo;
      vf = maj(mf[0], mf[1], mf[2]);
      for (int k = 0; k < 3; k++) begin
         if (rst) begin
            nf[k] = '0; no[k] = '0;
         end else if (inj_mask[k]) begin
            nf[k] = inj_value; no[k] = inj_value;
         end else begin
            nf[k] = vf + (en ? 1 : 0);
            no[k] = mo[k] + (en ? 1 : 0);
         end
      end
      @(posedge clk);
      #1;
      for (int k = 0; k < 3; k++) begin
         mf[k] = nf[k]; mo[k] = no[k];
      end
      vf = maj(mf[0], mf[1], mf[2]);
      vo = maj(mo[0], mo[1], mo[2]);
      for (int k = 0; k < 3; k++) begin
         ef[k] = (mf[k] != vf);
         eo[k] = (mo[k] != vo);
      end
      check(req, "fb count", 32'(cnt_fb), 32'(vf));
      check(req, "fb mismatch", 32'(mm_fb), 32'(ef));
      check(req, "oo count", 32'(cnt_oo), 32'(vo));
      check(req, "oo mismatch", 32'(mm_oo), 32'(eo));
   endtask

   task automatic do_reset();
      rst = 1'b1; inj_mask = 3'b000;
      step("R1");
      rst = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      logic [W-1:0] h;
      for (int k = 0; k < 3; k++) begin mf[k] = '0; mo[k] = '0; end
      #1;
      // R1: reset state
      do_reset();
      check("R1", "reset count", 32'(cnt_fb), 0);
      check("R1", "reset mismatch", 32'(mm_oo), 0);

      // R2: count through two wraps, arithmetic expectation
      en = 1'b1;
      for (int i = 0; i < 2 * M + 4; i++) begin
         step("R2");
         check("R2", "fb increment", 32'(cnt_fb), 32'((i + 1) % M));
         check("R2", "oo increment", 32'(cnt_oo), 32'((i + 1) % M));
      end

      // R3: hold
      en = 1'b0;
      h = cnt_fb;
      for (int i = 0; i < 4; i++) begin
         step("R3");
         check("R3", "fb hold", 32'(cnt_fb), 32'(h));
         check("R3", "oo hold", 32'(cnt_oo), 32'(h));
      end

      // R6/R7/R8: single upset in copy 0
      en = 1'b1; inj_mask = 3'b001; inj_value = h + 4'd7;
      step("R6");
      inj_mask = 3'b000;
      check("R6", "fb copy0 flagged", 32'(mm_fb), 1);
      check("R4", "fb outvoted", 32'(cnt_fb), 32'(W'(h + 1)));
      step("R7");
      check("R7", "fb realigned", 32'(mm_fb), 0);
      check("R7", "fb continues", 32'(cnt_fb), 32'(W'(h + 2)));
      check("R8", "oo still flagged", 32'(mm_oo), 1);
      check("R8", "oo count right", 32'(cnt_oo), 32'(W'(h + 2)));
      en = 1'b0;
      for (int i = 0; i < 3; i++) step("R8");
      check("R8", "oo flag persists when held", 32'(mm_oo), 1);
      do_reset();
      check("R8", "oo flag cleared by reset", 32'(mm_oo), 0);

      // R5/R6: every value into every copy
      for (int k = 0; k < 3; k++) begin
         for (int v = 0; v < M; v++) begin
            do_reset();
            en = 1'b1;
            step("R2");
            step("R2");
            inj_mask = 3'(1 << k); inj_value = W'(v);
            en = v[0];
            step("R5");
            inj_mask = 3'b000; en = 1'b1;
            step("R7");
            step("R8");
         end
      end

      // R9: double upset defeats the vote
      do_reset();
      en = 1'b1;
      repeat (3) step("R2");
      inj_mask = 3'b011; inj_value = 4'd10;
      step("R9");
      inj_mask = 3'b000;
      check("R9", "fb wrong output", 32'(cnt_fb), 10);
      check("R9", "oo wrong output", 32'(cnt_oo), 10);
      check("R9", "fb good copy flagged", 32'(mm_fb), 4);
      step("R9");
      check("R9", "fb adopts wrong value", 32'(cnt_fb), 11);

      // R4: three distinct copies in output-only mode
      do_reset();
      repeat (3) step("R2");
      inj_mask = 3'b001; inj_value = 4'b0011;
      step("R4");
      inj_mask = 3'b010; inj_value = 4'b1001;
      step("R4");
      inj_mask = 3'b000;
      repeat (4) step("R4");

      // R6: reset wins over injection
      rst = 1'b1; inj_mask = 3'b111; inj_value = 4'd7;
      step("R6");
      check("R6", "reset over inject fb", 32'(cnt_fb), 0);
      check("R6", "reset over inject oo", 32'(cnt_oo), 0);
      rst = 1'b0; inj_mask = 3'b000;
      step("R2");

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule